// File: doc/BRIEF.md
# Indirect PHY Configuration Port

This block gives a host an indirect path into a small bank of PHY configuration registers. The host does not address the bank directly. It writes one configuration word that packs a register address, a data nibble and a commit strobe. The block watches that word, pulls the fields out of it, and writes the bank on a low-to-high transition of the strobe. The addressed entry is always visible on a status word, so a read only needs the host to set the address field.

The status word also carries two PLL flags, passed through from inputs. Two decoded controls come out of the bank. One is a separate-rate select taken from bit 3 of entry 0x10. The other is a 100 MHz reference select taken from bit 3 of entry 0x12. A host bring-up sequence sets these through the same indirect writes.

Top module: `phy_cfg_port`

## Requirements
- R1: In `cfg_word`, bit 0 is the strobe, bits 6:1 are the register address and bits 10:7 are the write data. Bits 15:11 have no effect on any output.
- R2: When the strobe is sampled high at a clock edge after it was sampled low at the previous edge, the entry named by the address field takes the data field at that edge.
- R3: While the strobe stays high, changing the address or data fields writes nothing.
- R4: A falling strobe, or a strobe held low, writes nothing, whatever the address and data fields hold.
- R5: `status_word[3:0]` shows the entry named by the current address field in the same cycle, with no clock in between. Bits 8:4 and 15:11 of `status_word` are zero.
- R6: `status_word[9]` follows `pll_locked` and `status_word[10]` follows `pll_out_en`.
- R7: After reset every entry reads 0, and `sep_rate_sel` and `ref100_sel` are 0.
- R8: A strobe that is already high when reset is released is not a rising edge. It writes nothing until it has been sampled low and then high again.
- R9: `sep_rate_sel` equals bit 3 of entry 0x10 and `ref100_sel` equals bit 3 of entry 0x12.
- R10: A write changes only the addressed entry. Writing an address again replaces its earlier value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 16 | Host configuration word: strobe, address, data |
| pll_locked | input | 1 | PLL lock flag, reported in the status word |
| pll_out_en | input | 1 | PLL output state flag, reported in the status word |
| status_word | output | 16 | Addressed entry plus PLL flags |
| sep_rate_sel | output | 1 | Bit 3 of entry 0x10 |
| ref100_sel | output | 1 | Bit 3 of entry 0x12 |

## Verification
The hardest case to reach from the ports is a strobe held high across a change of address and data, or across the release of reset. Neither case can show up as a wrong value unless the bench reads back both the old and the new address afterwards. The bench therefore raises the strobe, rewrites the other fields while it stays high, and then reads both targets. It also holds the strobe high through reset release and confirms that only a later low-to-high transition commits.

// File: rtl/phy_cfg_port.sv
`timescale 1ns/1ps
module phy_cfg_port #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 4,
  parameter int CFG_W    = 16,
  parameter int STAT_W   = 16,
  parameter int LOCK_BIT = 9,
  parameter int OUT_BIT  = 10,
  parameter int SEP_ADDR = 16,
  parameter int REF_ADDR = 18,
  parameter int SEL_BIT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              pll_locked,
  input  logic              pll_out_en,
  output logic [STAT_W-1:0] status_word,
  output logic              sep_rate_sel,
  output logic              ref100_sel
);
  localparam int ADDR_LSB = 1;
  localparam int DATA_LSB = ADDR_LSB + ADDR_W;
  localparam int ENTRIES  = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] SEP_IDX = ADDR_W'(SEP_ADDR);
  localparam logic [ADDR_W-1:0] REF_IDX = ADDR_W'(REF_ADDR);

  logic                           strobe;
  logic [ADDR_W-1:0]              addr;
  logic [DATA_W-1:0]              data;
  logic                           strobe_q;
  logic                           commit;
  logic [ENTRIES-1:0][DATA_W-1:0] regs;

  assign strobe = cfg_word[0];
  assign addr   = cfg_word[DATA_LSB-1:ADDR_LSB];
  assign data   = cfg_word[DATA_LSB+DATA_W-1:DATA_LSB];
  assign commit = strobe & ~strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      regs     <= '0;
    end else begin
      strobe_q <= strobe;
      if (commit) regs[addr] <= data;
    end
  end

  always_comb begin
    status_word              = '0;
    status_word[DATA_W-1:0]  = regs[addr];
    status_word[LOCK_BIT]    = pll_locked;
    status_word[OUT_BIT]     = pll_out_en;
  end

  assign sep_rate_sel = regs[SEP_IDX][SEL_BIT];
  assign ref100_sel   = regs[REF_IDX][SEL_BIT];

  a_r2_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (regs[$past(addr)] == $past(data)));

  a_r3_held_strobe_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && strobe_q) |=> $stable(regs));

  a_r4_low_strobe_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(regs));

  a_r9_sel_change_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sep_rate_sel) || !$stable(ref100_sel)) |-> $past(commit));
endmodule

// File: tb/phy_cfg_port_bench.sv
`timescale 1ns/1ps
module phy_cfg_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_word = '0;
  logic        pll_locked = 1'b0;
  logic        pll_out_en = 1'b0;
  logic [15:0] status_word;
  logic        sep_rate_sel, ref100_sel;

  int errors = 0;
  int checks = 0;
  logic [3:0] shadow [64];

  always #2 clk = ~clk;

  phy_cfg_port u_phy_cfg_port (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .pll_locked(pll_locked), .pll_out_en(pll_out_en),
    .status_word(status_word), .sep_rate_sel(sep_rate_sel), .ref100_sel(ref100_sel));

  localparam int NV = 8;
  localparam logic [9:0] VEC [NV] = '{
    {6'h10, 4'h8}, {6'h12, 4'h8}, {6'h00, 4'h5}, {6'h3f, 4'hf},
    {6'h21, 4'ha}, {6'h00, 4'h3}, {6'h12, 4'h0}, {6'h07, 4'h6}};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] d);
    @(negedge clk) cfg_word = {5'b0, d, a, 1'b0};
    @(negedge clk) cfg_word[0] = 1'b1;
    @(negedge clk) cfg_word[0] = 1'b0;
    shadow[a] = d;
  endtask

  task automatic rd(input string req, input logic [5:0] a);
    @(negedge clk) cfg_word = {9'b0, a, 1'b0};
    #1 check(req, status_word, {5'b0, pll_out_en, pll_locked, 5'b0, shadow[a]});
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state
    rd("R7", 6'h00); rd("R7", 6'h10); rd("R7", 6'h3f);
    check("R7 sel", {14'b0, sep_rate_sel, ref100_sel}, 16'h0);

    // table walk: R2, R10, R9
    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][9:4], VEC[v][3:0]);
      rd("R2", VEC[v][9:4]);
      check("R9", {14'b0, sep_rate_sel, ref100_sel}, {14'b0, shadow[16][3], shadow[18][3]});
    end
    for (int a = 0; a < 64; a++) rd("R10", 6'(a));

    // R6 PLL flags and R5 zero bits
    pll_locked = 1'b1; rd("R6", 6'h07);
    pll_out_en = 1'b1; rd("R6", 6'h21);
    pll_locked = 1'b0; rd("R5", 6'h3f);
    pll_out_en = 1'b0;

    // R5 same-cycle read as address changes
    @(negedge clk) cfg_word = {9'b0, 6'h21, 1'b0};
    #1 check("R5", status_word, {12'b0, 4'ha});
    cfg_word = {9'b0, 6'h3f, 1'b0};
    #1 check("R5", status_word, {12'b0, 4'hf});

    // R1 upper bits ignored, including with a write
    @(negedge clk) cfg_word = {5'h1f, 4'h9, 6'h05, 1'b0};
    @(negedge clk) cfg_word[0] = 1'b1;
    @(negedge clk) cfg_word[0] = 1'b0;
    shadow[5] = 4'h9;
    #1 check("R1", status_word, {12'b0, 4'h9});
    rd("R1", 6'h05);

    // R3 hold strobe high, change fields
    @(negedge clk) cfg_word = {5'b0, 4'hc, 6'h08, 1'b0};
    @(negedge clk) cfg_word[0] = 1'b1;
    shadow[8] = 4'hc;
    @(negedge clk) cfg_word = {5'b0, 4'h1, 6'h09, 1'b1};
    @(negedge clk) cfg_word = {5'b0, 4'h2, 6'h08, 1'b1};
    @(negedge clk) cfg_word[0] = 1'b0;
    rd("R3", 6'h08); rd("R3", 6'h09);

    // R4 falling edge and low strobe with new fields
    @(negedge clk) cfg_word = {5'b0, 4'h7, 6'h0a, 1'b1};
    shadow[10] = 4'h7;
    @(negedge clk) cfg_word = {5'b0, 4'h4, 6'h0b, 1'b0};
    @(negedge clk) cfg_word = {5'b0, 4'h5, 6'h0a, 1'b0};
    @(negedge clk);
    rd("R4", 6'h0a); rd("R4", 6'h0b);

    // R8 strobe high across reset release
    @(negedge clk) rst_n = 1'b0;
    for (int i = 0; i < 64; i++) shadow[i] = 4'h0;
    cfg_word = {5'b0, 4'he, 6'h12, 1'b1};
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    #1 check("R8", status_word, 16'h0);
    check("R8 sel", {14'b0, sep_rate_sel, ref100_sel}, 16'h0);
    @(negedge clk) cfg_word[0] = 1'b0;
    @(negedge clk) cfg_word[0] = 1'b1;
    shadow[18] = 4'he;
    @(negedge clk) cfg_word[0] = 1'b0;
    rd("R8", 6'h12);
    check("R9", {14'b0, sep_rate_sel, ref100_sel}, 16'h0001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule